// File: doc/BRIEF.md
# Clock Source Selection Controller

This block is a byte-wide control register that decides whether the machine clock comes from the main oscillator or from a multiplied PLL output. Software writes a source request, a PLL multiplier code and an oscillation-stabilization wait code through a simple write/read port. A read-only status bit reports the source that actually drives the machine clock. When software asks to move to the PLL, the status bit keeps showing the main clock until the PLL reports that it is ready. The bit changes only after the switch has completed.

The block also holds the stabilization timer. A wake request starts a wait whose length is a power of two of oscillator cycles. The length is picked by the wait code, and one code means no wait at all. A done flag stays low while the wait runs. The PLL, the oscillator and the glitch-free clock multiplexer are outside this block. They are reached through the ready input and the select outputs.

Top module: `clksel_ctrl`

## Requirements
- R1: After reset the register reads 8'hFC (binary 11111100): main clock requested and active, wait code 11, multiplier code 00. The outputs are `use_main`=1, `mult_code`=00 and `stab_done`=1.
- R2: The read layout, from bit 7 down to bit 0, is: reserved (1), status, wait code [1:0], reserved (1), request, multiplier [1:0]. Bits 7 and 3 always read 1 whatever is written to them.
- R3: Bit 2 of a write sets the request, where 1 means main clock and 0 means PLL clock. The new value reads back from the clock edge that samples the write.
- R4: While the request is PLL and the status bit is 1, the status bit (bit 6, also output `use_main`) stays 1 at every edge where `pll_ready` is low. It clears to 0 at the first edge where `pll_ready` is sampled high.
- R5: When the request is main, the status bit is 1 from the next edge onward. After a write of request=1, status reads 1 from the second edge after the write.
- R6: Multiplier code 00/01/10/11 selects 1x/2x/3x/4x. The code is taken from bits 1:0 of a write and driven on `mult_code` while the status bit is 1 at the writing edge.
- R7: A write made while the status bit is 0 (PLL running) leaves the multiplier code unchanged. The request and wait fields are still written.
- R8: Wait code bits 5:4 choose the wake wait: 00 means no wait, 01 means 2^WAIT_EXP1 cycles, 10 means 2^WAIT_EXP2 cycles and 11 means 2^WAIT_EXP3 cycles (defaults 13, 15, 17). With code 00, `stab_done` is 1 right after the edge that samples `wake_req`.
- R9: With a non-zero wait code, a sampled `wake_req` drives `stab_done` low for exactly the selected number of cycles, and the flag then returns to 1.
- R10: A `wake_req` sampled while a wait is running restarts the wait from its full length.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Oscillator-domain clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_data | input | 8 | Write data |
| rd_data | output | 8 | Register read value |
| wake_req | input | 1 | Wake from stop mode, starts the stabilization wait |
| pll_ready | input | 1 | PLL locked and switch may complete |
| use_main | output | 1 | Machine clock source, 1 = main, 0 = PLL |
| mult_code | output | 2 | PLL multiplier code |
| stab_done | output | 1 | Stabilization wait finished |

## Verification
The assertions check on every cycle that the reserved bits read 1 and that the status bit holds or clears as `pll_ready` dictates during a switch to the PLL. They also check that the status bit returns to main one cycle after a main request, that the multiplier stays frozen while the PLL runs, and how `stab_done` reacts in the first cycle after a wake. Only the bench scenarios show the exact length of each stabilization wait, the restart of a wait, the reset value, and the whole register read-back across sequences of writes.

// File: rtl/clksel_pkg.sv
package clksel_pkg;

    typedef struct packed {
        logic       req_main;
        logic [1:0] wsel;
        logic [1:0] mult;
    } cfg_t;

    localparam logic [1:0] WSEL_NONE  = 2'b00;
    localparam cfg_t       CFG_RESET  = '{req_main: 1'b1, wsel: 2'b11, mult: 2'b00};

endpackage

// File: rtl/clksel_cfg_reg.sv
module clksel_cfg_reg
    import clksel_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       wr_en,
    input  logic [7:0] wr_data,
    input  logic       main_active,
    output cfg_t       cfg
);

    cfg_t cfg_d, cfg_q;

    always_comb begin
        cfg_d = cfg_q;
        if (wr_en) begin
            cfg_d.req_main = wr_data[2];
            cfg_d.wsel     = wr_data[5:4];
            // multiplier frozen while PLL drives the machine clock
            if (main_active) begin
                cfg_d.mult = wr_data[1:0];
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cfg_q <= CFG_RESET;
        end else begin
            cfg_q <= cfg_d;
        end
    end

    assign cfg = cfg_q;

endmodule

// File: rtl/clksel_switch_track.sv
module clksel_switch_track (
    input  logic clk,
    input  logic rst_n,
    input  logic req_main,
    input  logic pll_ready,
    output logic main_active
);

    logic act_d, act_q;

    always_comb begin
        act_d = act_q;
        if (req_main) begin
            act_d = 1'b1;
        end else if (act_q && pll_ready) begin
            act_d = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            act_q <= 1'b1;
        end else begin
            act_q <= act_d;
        end
    end

    assign main_active = act_q;

endmodule

// File: rtl/clksel_stab_timer.sv
module clksel_stab_timer
    import clksel_pkg::*;
#(
    parameter int WAIT_EXP1 = 13,
    parameter int WAIT_EXP2 = 15,
    parameter int WAIT_EXP3 = 17
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       wake_req,
    input  logic [1:0] wsel,
    output logic       done
);

    localparam int CW = WAIT_EXP3;
    localparam logic [CW-1:0] LAST1 = {CW{1'b1}} >> (WAIT_EXP3 - WAIT_EXP1);
    localparam logic [CW-1:0] LAST2 = {CW{1'b1}} >> (WAIT_EXP3 - WAIT_EXP2);
    localparam logic [CW-1:0] LAST3 = {CW{1'b1}};

    typedef struct packed {
        logic          done;
        logic [CW-1:0] cnt;
    } tmr_t;

    tmr_t st_d, st_q;
    logic [CW-1:0] load_val;

    always_comb begin
        unique case (wsel)
            2'b01:   load_val = LAST1;
            2'b10:   load_val = LAST2;
            2'b11:   load_val = LAST3;
            default: load_val = '0;
        endcase
    end

    always_comb begin
        st_d = st_q;
        if (wake_req) begin
            st_d.cnt  = load_val;
            st_d.done = (wsel == WSEL_NONE);
        end else if (!st_q.done) begin
            if (st_q.cnt == '0) begin
                st_d.done = 1'b1;
            end else begin
                st_d.cnt = st_q.cnt - 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '{done: 1'b1, cnt: '0};
        end else begin
            st_q <= st_d;
        end
    end

    assign done = st_q.done;

endmodule

// File: rtl/clksel_ctrl.sv
module clksel_ctrl
    import clksel_pkg::*;
#(
    parameter int WAIT_EXP1 = 13,
    parameter int WAIT_EXP2 = 15,
    parameter int WAIT_EXP3 = 17
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       wr_en,
    input  logic [7:0] wr_data,
    output logic [7:0] rd_data,
    input  logic       wake_req,
    input  logic       pll_ready,
    output logic       use_main,
    output logic [1:0] mult_code,
    output logic       stab_done
);

    cfg_t cfg;
    logic main_active;

    clksel_cfg_reg u_cfg (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_en      (wr_en),
        .wr_data    (wr_data),
        .main_active(main_active),
        .cfg        (cfg)
    );

    clksel_switch_track u_track (
        .clk        (clk),
        .rst_n      (rst_n),
        .req_main   (cfg.req_main),
        .pll_ready  (pll_ready),
        .main_active(main_active)
    );

    clksel_stab_timer #(
        .WAIT_EXP1(WAIT_EXP1),
        .WAIT_EXP2(WAIT_EXP2),
        .WAIT_EXP3(WAIT_EXP3)
    ) u_timer (
        .clk     (clk),
        .rst_n   (rst_n),
        .wake_req(wake_req),
        .wsel    (cfg.wsel),
        .done    (stab_done)
    );

    assign rd_data   = {1'b1, main_active, cfg.wsel, 1'b1, cfg.req_main, cfg.mult};
    assign use_main  = main_active;
    assign mult_code = cfg.mult;

endmodule

// File: rtl/clksel_ctrl_chk.sv
module clksel_ctrl_chk (
    input logic       clk,
    input logic       rst_n,
    input logic [7:0] rd_data,
    input logic       wake_req,
    input logic       pll_ready,
    input logic       use_main,
    input logic [1:0] mult_code,
    input logic       stab_done
);

    AST_RSVD_READ_ONE: assert property (@(posedge clk) disable iff (!rst_n)
        rd_data[7] && rd_data[3]); // R2

    AST_STATUS_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        use_main && !rd_data[2] && !pll_ready |=> use_main); // R4

    AST_STATUS_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        use_main && !rd_data[2] && pll_ready |=> !use_main); // R4

    AST_BACK_TO_MAIN: assert property (@(posedge clk) disable iff (!rst_n)
        rd_data[2] |=> use_main); // R5

    AST_MULT_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
        !use_main |=> $stable(mult_code)); // R7

    AST_NO_WAIT_DONE: assert property (@(posedge clk) disable iff (!rst_n)
        wake_req && (rd_data[5:4] == 2'b00) |=> stab_done); // R8

    AST_WAIT_STARTS: assert property (@(posedge clk) disable iff (!rst_n)
        wake_req && (rd_data[5:4] != 2'b00) |=> !stab_done); // R9

endmodule

bind clksel_ctrl clksel_ctrl_chk u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .rd_data  (rd_data),
    .wake_req (wake_req),
    .pll_ready(pll_ready),
    .use_main (use_main),
    .mult_code(mult_code),
    .stab_done(stab_done)
);

// File: tb/clksel_ctrl_tb.sv
module clksel_ctrl_tb;

    localparam int E1 = 2;
    localparam int E2 = 3;
    localparam int E3 = 4;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       wr_en = 1'b0;
    logic [7:0] wr_data = 8'h00;
    logic [7:0] rd_data;
    logic       wake_req = 1'b0;
    logic       pll_ready = 1'b0;
    logic       use_main;
    logic [1:0] mult_code;
    logic       stab_done;

    int total = 0;
    int bad = 0;
    bit finished = 1'b0;

    always #2 clk = ~clk;

    clksel_ctrl #(.WAIT_EXP1(E1), .WAIT_EXP2(E2), .WAIT_EXP3(E3)) u_dut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
        .rd_data(rd_data), .wake_req(wake_req), .pll_ready(pll_ready),
        .use_main(use_main), .mult_code(mult_code), .stab_done(stab_done)
    );

    // {write value, pll_ready, expected read after two edges}
    typedef struct packed {
        logic [7:0] wv;
        logic       rdy;
        logic [7:0] exp;
    } vec_t;

    localparam int NV = 7;
    localparam vec_t VECS [NV] = '{
        '{wv: 8'h01, rdy: 1'b0, exp: 8'hC9},  // R3 PLL requested, R4 status holds
        '{wv: 8'h02, rdy: 1'b1, exp: 8'h8A},  // R4 clears on ready, R6 mult 10
        '{wv: 8'h33, rdy: 1'b1, exp: 8'hBA},  // R7 mult ignored, R2 rsvd
        '{wv: 8'h14, rdy: 1'b1, exp: 8'hDE},  // R5 back to main, R7
        '{wv: 8'h27, rdy: 1'b0, exp: 8'hEF},  // R6 mult 11 accepted
        '{wv: 8'h00, rdy: 1'b0, exp: 8'hC8},  // R2 rsvd forced, R3
        '{wv: 8'hFC, rdy: 1'b0, exp: 8'hFC}   // R3 main again
    };

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic cyc(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic wr(input logic [7:0] v);
        wr_en = 1'b1;
        wr_data = v;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic wake_and_count(input string req, input int expect_len);
        int lows;
        wake_req = 1'b1;
        @(negedge clk);
        wake_req = 1'b0;
        lows = 0;
        while (!stab_done && lows < 1000) begin
            lows++;
            @(negedge clk);
        end
        chk(req, lows, expect_len);
    endtask

    task automatic finish_run();
        if (!finished) begin
            finished = 1'b1;
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    endtask

    initial begin
        for (int c = 0; c < 20000; c++) @(posedge clk);
        bad++;
        total++;
        $display("FAIL watchdog: actual=timeout expected=completion");
        finish_run();
    end

    initial begin
        cyc(3);
        // R1 reset state
        chk("R1 rd", rd_data, 8'hFC);
        chk("R1 use_main", use_main, 1);
        chk("R1 mult", mult_code, 0);
        chk("R1 done", stab_done, 1);
        rst_n = 1'b1;
        cyc(1);
        chk("R1 rd after release", rd_data, 8'hFC);

        // table walk
        for (int i = 0; i < NV; i++) begin
            pll_ready = VECS[i].rdy;
            wr(VECS[i].wv);
            cyc(1);
            chk("R2/R3/R4/R5/R6/R7 rd", rd_data, VECS[i].exp);
            chk("R4/R5 use_main", use_main, VECS[i].exp[6]);
            chk("R6/R7 mult_code", mult_code, VECS[i].exp[1:0]);
        end
        pll_ready = 1'b0;

        // R3 request visible at the writing edge, R4 hold over many cycles
        wr(8'hF9);
        chk("R3 req visible", rd_data[2], 0);
        cyc(6);
        chk("R4 held without ready", use_main, 1);
        pll_ready = 1'b1;
        cyc(1);
        pll_ready = 1'b0;
        chk("R4 cleared on ready edge", use_main, 0);
        chk("R7 mult kept at 01", mult_code, 2'b01);
        // R5 lag of one cycle
        wr(8'h0E);
        chk("R5 status still PLL at write edge", use_main, 0);
        chk("R7 mult unchanged", mult_code, 2'b01);
        cyc(1);
        chk("R5 status main one cycle later", use_main, 1);

        // R8 no wait
        wr(8'h0C);
        wake_req = 1'b1;
        cyc(1);
        wake_req = 1'b0;
        chk("R8 no-wait done", stab_done, 1);

        // R9 each wait length
        wr(8'h1C);
        wake_and_count("R9 code01", 1 << E1);
        wr(8'h2C);
        wake_and_count("R9 code10", 1 << E2);
        wr(8'h3C);
        wake_and_count("R9 code11", 1 << E3);

        // R10 restart
        wake_req = 1'b1;
        cyc(1);
        wake_req = 1'b0;
        cyc(5);
        chk("R10 still waiting", stab_done, 0);
        wake_and_count("R10 restart full length", 1 << E3);

        finish_run();
    end

endmodule